// File: doc/BRIEF.md
# Halt Mode Wakeup Sequencer

This block controls the low-power halt state of a small processor core. Software halts the core by writing 1 to a halt flag. The controller then drops the core clock enable and waits for one of the wakeup events. A board strap can turn the halt feature off, and then the write is ignored.

Three events end a halt. The first is a strobe from the multi-input wakeup logic. The second is a rising edge on the clock-out pin, which counts only when the board uses an RC oscillator. The third is a synchronous reset. After a strobe or pin wakeup, the controller may hold the core clocks off while the oscillator settles. This hold is a down-count of `STAB_COUNT` ticks, and each tick is the oscillator clock divided by `DIV`. A crystal oscillator always gets the hold. An RC oscillator gets it only when a delay-enable bit is set.

Top module: `halt_wake_seq`

## Requirements
- R1: After reset, `core_clk_en` is 1, `halt_flag` is 0 and the internal delay-enable bit is 0.
- R2: In the running state, with `halt_dis` = 0, a cycle with `halt_wr` = 1 and `halt_wr_data` = 1 makes `halt_flag` 1 and `core_clk_en` 0 from the next cycle on. A write with `halt_wr_data` = 0 has no effect.
- R3: When `halt_dis` = 1, a halt write has no effect: `halt_flag` stays 0 and `core_clk_en` stays 1.
- R4: While halted, `core_clk_en` is 0 and `halt_flag` stays 1 until a wakeup event is accepted.
- R5: While halted, `mi_wake` = 1 in a cycle clears `halt_flag` in the next cycle.
- R6: A rising edge on `ck_pin` (0 in one cycle, 1 in the next) wakes a halted controller only when `osc_is_rc` = 1. When `osc_is_rc` = 0 the edge is ignored and `halt_flag` stays 1.
- R7: With `osc_is_rc` = 0, an accepted wakeup is followed by exactly `DIV*STAB_COUNT` cycles with `halt_flag` = 0 and `core_clk_en` = 0, and `core_clk_en` is 1 after them.
- R8: With `osc_is_rc` = 1, the delay of R7 applies when the delay-enable bit is 1. When the bit is 0, `core_clk_en` is 1 in the cycle right after the wakeup.
- R9: The delay-enable bit takes `dly_wdata` in a cycle with `dly_wr` = 1, holds its value otherwise, and is cleared by reset.
- R10: Reset asserted while halted or while waiting for the delay returns the controller to running, with `halt_flag` 0 and `core_clk_en` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset, also a wakeup source |
| halt_wr | input | 1 | Write strobe for the halt flag |
| halt_wr_data | input | 1 | Value written to the halt flag |
| mi_wake | input | 1 | Multi-input wakeup strobe |
| ck_pin | input | 1 | Level of the clock-out pin, synchronous to clk |
| osc_is_rc | input | 1 | Strap: 1 = RC oscillator, 0 = crystal |
| halt_dis | input | 1 | Strap: 1 = halt feature disabled |
| dly_wr | input | 1 | Write strobe for the delay-enable bit |
| dly_wdata | input | 1 | Value written to the delay-enable bit |
| core_clk_en | output | 1 | Clock enable for the rest of the core |
| halt_flag | output | 1 | Halt status, 1 while halted |

## Verification
The assertions check on every cycle that a halt always gates the core clock. They also check that halt entry follows a valid write, that a disabled strap keeps the core running, that the wakeup strobe ends a halt, and that the pin is ignored with a crystal. A cycle counter in the checker compares the length of every settling window with `DIV*STAB_COUNT`. Only the bench scenarios can show the whole run of events. That run covers writing the delay bit, then a halt, then a pin or strobe wakeup, then the measured hold. It also shows the delay bit being cleared by reset, and a reset arriving in the middle of a halt or a hold.

// File: rtl/hws_pkg.sv
// Package: shared state encoding of the halt/wakeup sequencer.
// Assumes nothing beyond a two-bit state register.
package hws_pkg;
    typedef enum logic [1:0] {
        HWS_RUN    = 2'd0,
        HWS_HALTED = 2'd1,
        HWS_STAB   = 2'd2
    } hws_state_t;
endpackage

// File: rtl/hws_rise_det.sv
// Rising-edge detector for a pin level that is already synchronous to clk.
// The previous level resets to 1, so a pin that is high out of reset
// does not produce a false edge.
module hws_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic prev_q;

    // Purpose: remember the pin level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin;
    end

    // Purpose: flag a 0-to-1 change of the pin.
    always_comb rise = pin & ~prev_q;
endmodule

// File: rtl/hws_prescale.sv
// Divide-by-DIV tick generator. While run is low it holds its count at 0,
// so the first tick comes DIV cycles after run rises.
// Assumes DIV >= 2.
module hws_prescale #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Purpose: cycle count within one divided period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: one-cycle pulse at the end of each divided period.
    always_comb tick = run && (cnt_q == LAST);
endmodule

// File: rtl/hws_stab_cnt.sv
// Stabilization down-counter. It is loaded with STAB_COUNT and counts one
// step per tick. done pulses on the tick that would take it from 1 to 0.
// Assumes STAB_COUNT >= 1.
module hws_stab_cnt #(
    parameter int STAB_COUNT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(STAB_COUNT + 1);
    localparam logic [W-1:0] INIT = W'(STAB_COUNT);

    logic [W-1:0] cnt_q;

    // Purpose: hold the number of ticks still to wait.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= INIT;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: signal expiry on the final tick.
    always_comb done = tick && (cnt_q == W'(1));
endmodule

// File: rtl/halt_wake_seq.sv
// Halt mode wakeup sequencer, top level.
// It gates the core clock enable while halted. It accepts a wakeup strobe,
// or a clock-out pin rising edge when the board uses an RC oscillator.
// It can then hold the clocks off for DIV*STAB_COUNT cycles while the
// oscillator settles. Reset is synchronous, active low, and is the third
// wakeup source. Assumes all inputs are synchronous to clk.
module halt_wake_seq #(
    parameter int DIV        = 10,
    parameter int STAB_COUNT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_wr,
    input  logic halt_wr_data,
    input  logic mi_wake,
    input  logic ck_pin,
    input  logic osc_is_rc,
    input  logic halt_dis,
    input  logic dly_wr,
    input  logic dly_wdata,
    output logic core_clk_en,
    output logic halt_flag
);
    import hws_pkg::*;

    hws_state_t st_q, st_nx;
    logic       dly_q;
    logic       pin_rise;
    logic       tick;
    logic       stab_done;
    logic       stab_load;
    logic       wake;
    logic       need_dly;

    // Purpose: software-visible delay-enable bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dly_q <= 1'b0;
        else if (dly_wr) dly_q <= dly_wdata;
    end

    hws_rise_det u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ck_pin),
        .rise (pin_rise)
    );

    hws_prescale #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q == HWS_STAB),
        .tick (tick)
    );

    hws_stab_cnt #(.STAB_COUNT(STAB_COUNT)) u_stab (
        .clk  (clk),
        .rst_n(rst_n),
        .load (stab_load),
        .tick (tick),
        .done (stab_done)
    );

    // Purpose: decide which wakeups count and whether settling is needed.
    always_comb begin
        wake     = mi_wake | (pin_rise & osc_is_rc);
        need_dly = ~osc_is_rc | dly_q;
    end

    // Purpose: next-state logic of the power-state machine.
    always_comb begin
        st_nx     = st_q;
        stab_load = 1'b0;
        case (st_q)
            HWS_RUN: begin
                if (halt_wr && halt_wr_data && !halt_dis) st_nx = HWS_HALTED;
            end
            HWS_HALTED: begin
                if (wake) begin
                    if (need_dly) begin
                        st_nx     = HWS_STAB;
                        stab_load = 1'b1;
                    end else begin
                        st_nx = HWS_RUN;
                    end
                end
            end
            HWS_STAB: begin
                if (stab_done) st_nx = HWS_RUN;
            end
            default: st_nx = HWS_RUN;
        endcase
    end

    // Purpose: state register; reset always lands in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HWS_RUN;
        else        st_q <= st_nx;
    end

    // Purpose: drive the outputs from the state.
    always_comb begin
        core_clk_en = (st_q == HWS_RUN);
        halt_flag   = (st_q == HWS_HALTED);
    end
endmodule

// File: rtl/hws_chk.sv
// Checker for halt_wake_seq, bound to every instance.
// It samples ports plus the delay-enable bit, and uses a counter to measure
// each settling window instead of a long $past.
module hws_chk #(
    parameter int DIV        = 10,
    parameter int STAB_COUNT = 256
) (
    input logic clk,
    input logic rst_n,
    input logic halt_wr,
    input logic halt_wr_data,
    input logic halt_dis,
    input logic mi_wake,
    input logic osc_is_rc,
    input logic dly_q,
    input logic core_clk_en,
    input logic halt_flag
);
    localparam int N  = DIV * STAB_COUNT;
    localparam int CW = $clog2(N + 1) + 1;

    logic [CW-1:0] win_q;

    // Purpose: length of the current or just-ended settling window.
    always_ff @(posedge clk) begin
        if (!rst_n)                         win_q <= '0;
        else if (!core_clk_en && !halt_flag) win_q <= win_q + 1'b1;
        else                                win_q <= '0;
    end

    p_halt_gates_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_flag |-> !core_clk_en);

    p_enter_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && halt_wr && halt_wr_data && !halt_dis) |=> halt_flag);

    p_strap_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && halt_dis) |=> (core_clk_en && !halt_flag));

    p_strobe_wakes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_flag && mi_wake) |=> !halt_flag);

    p_xtal_pin_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_flag && !osc_is_rc && !mi_wake) |=> halt_flag);

    p_xtal_delays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_flag && mi_wake && !osc_is_rc) |=> (!core_clk_en && !halt_flag));

    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && !halt_flag) |-> (win_q < CW'(N)));

    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && win_q != '0) |-> (win_q == CW'(N)));

    p_rc_no_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_flag && mi_wake && osc_is_rc && !dly_q) |=> core_clk_en);
endmodule

bind halt_wake_seq hws_chk #(.DIV(DIV), .STAB_COUNT(STAB_COUNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_wr     (halt_wr),
    .halt_wr_data(halt_wr_data),
    .halt_dis    (halt_dis),
    .mi_wake     (mi_wake),
    .osc_is_rc   (osc_is_rc),
    .dly_q       (dly_q),
    .core_clk_en (core_clk_en),
    .halt_flag   (halt_flag)
);

// File: tb/sim_halt_wake_seq.sv
`timescale 1ns/1ps
// Bench: sweeps every mix of oscillator strap, delay bit, wakeup source and
// halt-disable strap. Settling lengths are worked out as DIV*STAB_COUNT.
module sim_halt_wake_seq;
    localparam int DIV        = 10;
    localparam int STAB_COUNT = 256;
    localparam int WIN        = DIV * STAB_COUNT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_wr = 1'b0, halt_wr_data = 1'b0, mi_wake = 1'b0, ck_pin = 1'b0;
    logic osc_is_rc = 1'b0, halt_dis = 1'b0, dly_wr = 1'b0, dly_wdata = 1'b0;
    logic core_clk_en, halt_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    halt_wake_seq #(.DIV(DIV), .STAB_COUNT(STAB_COUNT)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .halt_wr_data(halt_wr_data),
        .mi_wake(mi_wake), .ck_pin(ck_pin), .osc_is_rc(osc_is_rc),
        .halt_dis(halt_dis), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
        .core_clk_en(core_clk_en), .halt_flag(halt_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: wait for the edge, then settle past it before sampling.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic halt_write(input logic d);
        halt_wr = 1'b1;
        halt_wr_data = d;
        step();
        halt_wr = 1'b0;
        halt_wr_data = 1'b0;
    endtask

    task automatic write_dly(input logic d);
        dly_wr = 1'b1;
        dly_wdata = d;
        step();
        dly_wr = 1'b0;
    endtask

    // Counts the cycles with both outputs low, up to a bound.
    task automatic measure_window(output int n);
        n = 0;
        while (!core_clk_en && !halt_flag && n < WIN + 50) begin
            n++;
            step();
        end
    endtask

    // rc: oscillator strap; dly: delay bit; pin_src: wake by pin edge; dis: strap.
    task automatic run_case(input logic rc, input logic dly, input logic pin_src,
                            input logic dis);
        int n;
        int exp_win;
        osc_is_rc = rc;
        halt_dis = dis;
        ck_pin = 1'b0;
        do_reset();
        check("R1 clk_en after reset", core_clk_en, 1);
        check("R1 flag after reset", halt_flag, 0);
        write_dly(dly);
        halt_write(1'b0);
        check("R2 zero write ignored", halt_flag, 0);
        halt_write(1'b1);
        if (dis) begin
            check("R3 flag stays 0", halt_flag, 0);
            check("R3 clk_en stays 1", core_clk_en, 1);
            return;
        end
        check("R2 flag set", halt_flag, 1);
        check("R2 clk_en off", core_clk_en, 0);
        repeat (5) step();
        check("R4 still halted", halt_flag, 1);
        if (pin_src) begin
            ck_pin = 1'b0;
            step();
            ck_pin = 1'b1;
            step();
            if (!rc) begin
                check("R6 pin edge ignored in crystal mode", halt_flag, 1);
                check("R6 clk_en still off", core_clk_en, 0);
                mi_wake = 1'b1;
                step();
                mi_wake = 1'b0;
            end else begin
                check("R6 pin edge wakes in RC mode", halt_flag, 0);
            end
        end else begin
            mi_wake = 1'b1;
            step();
            mi_wake = 1'b0;
            check("R5 strobe clears flag", halt_flag, 0);
        end
        exp_win = (rc && !dly) ? 0 : WIN;
        measure_window(n);
        if (rc) check("R8 settle length in RC mode", n, exp_win);
        else    check("R7 settle length in crystal mode", n, exp_win);
        check("R7 clk_en back on", core_clk_en, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            run_case(logic'(i[0]), logic'(i[1]), logic'(i[2]), logic'(i[3]));
        end

        // R9: reset clears the delay bit, so an RC wakeup does not wait.
        osc_is_rc = 1'b1;
        halt_dis = 1'b0;
        do_reset();
        write_dly(1'b1);
        do_reset();
        halt_write(1'b1);
        mi_wake = 1'b1;
        step();
        mi_wake = 1'b0;
        check("R9 delay bit cleared by reset", core_clk_en, 1);

        // R9: the bit holds its value when not written.
        write_dly(1'b1);
        repeat (3) step();
        halt_write(1'b1);
        mi_wake = 1'b1;
        step();
        mi_wake = 1'b0;
        check("R9 delay bit retained", core_clk_en, 0);

        // R10: reset during the settling window.
        repeat (100) step();
        do_reset();
        check("R10 run after reset in window", core_clk_en, 1);
        check("R10 flag clear after reset in window", halt_flag, 0);

        // R10: reset while halted.
        osc_is_rc = 1'b0;
        halt_write(1'b1);
        check("R10 halted before reset", halt_flag, 1);
        do_reset();
        check("R10 run after reset in halt", core_clk_en, 1);
        check("R10 flag clear after reset in halt", halt_flag, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule